// File: doc/BRIEF.md
# Host Bus Operand Loader and Result Unloader

This block sits between a 32-bit host data bus and a key-stretching engine. While the host holds the input-enable line high, one bus word enters a wide input store on each clock. The store is cut into three fixed fields: a 512-bit padded key, a 160-bit first block and a 32-bit iteration count. These fields feed the engine directly. When the host drops input-enable, the block issues a single-cycle start pulse that launches the engine.

When the engine's 160-bit result is ready, a load strobe copies it into an output store. The top word of the output store always drives the outbound bus. While output-enable is high, the store moves one word per clock toward the bus, most-significant word first. Tri-state pads and all hashing are outside this block.

Top module: `hostio_xfer`

## Requirements
- R1: After reset (active-low `rst_n`), `start_pulse` is 0, `key_field`, `block_field` and `iter_count` are all zero, and `bus_out` is zero.
- R2: On each clock with `in_en` high, the word on `bus_in` is shifted into the input store at the least-significant end. Words fill most-significant first, so the word sent last appears in `iter_count` after that clock.
- R3: After 22 consecutive words, the first word sent is in `key_field[511:480]`. Word i (0-based) lands in `key_field[511-32i -: 32]` for i below 16, and in `block_field[159-32(i-16) -: 32]` for i from 16 to 20. Word 21 is in `iter_count`.
- R4: On a clock with `in_en` low, the three fields keep their values whatever `bus_in` carries.
- R5: When `in_en` is sampled low at a clock after being sampled high at the previous clock, `start_pulse` is 1 for exactly the one cycle following that clock. This holds even if `in_en` was high for only one cycle.
- R6: A rising edge of `in_en`, or `in_en` held steady at either level, never produces `start_pulse`.
- R7: On a clock with `res_load` high, `res_word` is captured whole, and `bus_out` shows `res_word[159:128]` in the following cycle.
- R8: On each clock with `out_en` high and `res_load` low, the output store shifts one word toward the bus, most-significant first. After five such clocks, `bus_out` is zero.
- R9: When `res_load` and `out_en` are both high on a clock, the load wins and no shift takes place.
- R10: On a clock with both `out_en` and `res_load` low, `bus_out` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_en | input | 1 | Input-enable: shift `bus_in` in while high; its falling edge starts the engine |
| bus_in | input | 32 | Inbound host bus word |
| res_load | input | 1 | Strobe that captures `res_word` into the output store |
| res_word | input | 160 | Result value from the engine |
| out_en | input | 1 | Output-enable: shift one word toward `bus_out` per clock |
| bus_out | output | 32 | Outbound host bus word (top of the output store) |
| start_pulse | output | 1 | One-cycle start after a falling edge of `in_en` |
| key_field | output | 512 | Padded key field of the input store |
| block_field | output | 160 | First-block field of the input store |
| iter_count | output | 32 | Iteration count field of the input store |

## Verification
The checker watches several properties on every cycle:
- the start pulse lasts one cycle and only ever follows a high-then-low sample of `in_en`;
- the newest bus word always arrives in the count field;
- the fields and the outbound word stay frozen when idle;
- a load puts the top result word on the bus on the next cycle, even when `out_en` is also high.

Some behaviours span many cycles, and only the bench scenarios show them. These are where each of the 22 words finally lands across the key, block and count fields, the order of the five words during unloading, and the store reaching zero after five shifts.

// File: rtl/hostio_pkg.sv
package hostio_pkg;
    localparam int unsigned HOST_BUS_W = 32;
    localparam int unsigned HOST_KEY_W = 512;
    localparam int unsigned HOST_BLK_W = 160;
    localparam int unsigned HOST_CNT_W = 32;
    localparam int unsigned HOST_RES_W = 160;

    function automatic int unsigned words_for(input int unsigned bits, input int unsigned bus_w);
        return (bits + bus_w - 1) / bus_w;
    endfunction
endpackage

// File: rtl/hostio_in_shift.sv
module hostio_in_shift #(
    parameter int unsigned BUS_W = 32,
    parameter int unsigned KEY_W = 512,
    parameter int unsigned BLK_W = 160,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [BUS_W-1:0] word_in,
    output logic [KEY_W-1:0] key_o,
    output logic [BLK_W-1:0] blk_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int unsigned STORE_W = KEY_W + BLK_W + CNT_W;
    localparam int unsigned N_WORDS = hostio_pkg::words_for(STORE_W, BUS_W);

    generate
        if (N_WORDS * BUS_W != STORE_W) begin : g_bad_width
            $error("input store width must be a whole number of bus words");
        end
    endgenerate

    typedef struct packed {
        logic [STORE_W-1:0] store;
    } in_state_t;

    in_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.store = {st_q.store[STORE_W-BUS_W-1:0], word_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_o = st_q.store[STORE_W-1 -: KEY_W];
    assign blk_o = st_q.store[CNT_W +: BLK_W];
    assign cnt_o = st_q.store[CNT_W-1:0];
endmodule

// File: rtl/hostio_fall_detect.sv
module hostio_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.prev  = level_i;
        st_d.pulse = st_q.prev & ~level_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/hostio_out_shift.sv
module hostio_out_shift #(
    parameter int unsigned BUS_W = 32,
    parameter int unsigned RES_W = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [RES_W-1:0] data_i,
    input  logic             shift_en,
    output logic [BUS_W-1:0] word_o
);
    localparam int unsigned N_WORDS = hostio_pkg::words_for(RES_W, BUS_W);

    generate
        if (N_WORDS * BUS_W != RES_W) begin : g_bad_width
            $error("result width must be a whole number of bus words");
        end
    endgenerate

    typedef struct packed {
        logic [RES_W-1:0] store;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.store = data_i;
        end else if (shift_en) begin
            st_d.store = {st_q.store[RES_W-BUS_W-1:0], {BUS_W{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.store[RES_W-1 -: BUS_W];
endmodule

// File: rtl/hostio_xfer.sv
module hostio_xfer #(
    parameter int unsigned BUS_W = hostio_pkg::HOST_BUS_W,
    parameter int unsigned KEY_W = hostio_pkg::HOST_KEY_W,
    parameter int unsigned BLK_W = hostio_pkg::HOST_BLK_W,
    parameter int unsigned CNT_W = hostio_pkg::HOST_CNT_W,
    parameter int unsigned RES_W = hostio_pkg::HOST_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic [BUS_W-1:0] bus_in,
    input  logic             res_load,
    input  logic [RES_W-1:0] res_word,
    input  logic             out_en,
    output logic [BUS_W-1:0] bus_out,
    output logic             start_pulse,
    output logic [KEY_W-1:0] key_field,
    output logic [BLK_W-1:0] block_field,
    output logic [CNT_W-1:0] iter_count
);
    hostio_in_shift #(
        .BUS_W(BUS_W), .KEY_W(KEY_W), .BLK_W(BLK_W), .CNT_W(CNT_W)
    ) u_in (
        .clk(clk), .rst_n(rst_n), .shift_en(in_en), .word_in(bus_in),
        .key_o(key_field), .blk_o(block_field), .cnt_o(iter_count)
    );

    hostio_fall_detect u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(in_en), .pulse_o(start_pulse)
    );

    hostio_out_shift #(
        .BUS_W(BUS_W), .RES_W(RES_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .load_i(res_load), .data_i(res_word),
        .shift_en(out_en), .word_o(bus_out)
    );
endmodule

// File: rtl/hostio_xfer_chk.sv
module hostio_xfer_chk #(
    parameter int unsigned BUS_W = 32,
    parameter int unsigned KEY_W = 512,
    parameter int unsigned BLK_W = 160,
    parameter int unsigned CNT_W = 32,
    parameter int unsigned RES_W = 160
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_en,
    input logic [BUS_W-1:0] bus_in,
    input logic             res_load,
    input logic [RES_W-1:0] res_word,
    input logic             out_en,
    input logic [BUS_W-1:0] bus_out,
    input logic             start_pulse,
    input logic [KEY_W-1:0] key_field,
    input logic [BLK_W-1:0] block_field,
    input logic [CNT_W-1:0] iter_count
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |=> !start_pulse); // R5
    AST_START_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |-> (!$past(in_en) && $past(in_en, 2))); // R6
    AST_NEWEST_IN_COUNT: assert property (@(posedge clk) disable iff (!rst_n) in_en |=> (iter_count[BUS_W-1:0] == $past(bus_in))); // R2
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_en |=> ($stable(key_field) && $stable(block_field) && $stable(iter_count))); // R4
    AST_LOAD_TOP_WORD: assert property (@(posedge clk) disable iff (!rst_n) res_load |=> (bus_out == $past(res_word[RES_W-1 -: BUS_W]))); // R7 R9
    AST_OUT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!out_en && !res_load) |=> $stable(bus_out)); // R10
endmodule

bind hostio_xfer hostio_xfer_chk #(
    .BUS_W(BUS_W), .KEY_W(KEY_W), .BLK_W(BLK_W), .CNT_W(CNT_W), .RES_W(RES_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .bus_in(bus_in),
    .res_load(res_load), .res_word(res_word), .out_en(out_en),
    .bus_out(bus_out), .start_pulse(start_pulse), .key_field(key_field),
    .block_field(block_field), .iter_count(iter_count)
);

// File: tb/tb_hostio_xfer.sv
`timescale 1ns/1ps
module tb_hostio_xfer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_en = 1'b0;
    logic [31:0]  bus_in = '0;
    logic         res_load = 1'b0;
    logic [159:0] res_word = '0;
    logic         out_en = 1'b0;
    logic [31:0]  bus_out;
    logic         start_pulse;
    logic [511:0] key_field;
    logic [159:0] block_field;
    logic [31:0]  iter_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hostio_xfer dut (
        .clk(clk), .rst_n(rst_n), .in_en(in_en), .bus_in(bus_in),
        .res_load(res_load), .res_word(res_word), .out_en(out_en),
        .bus_out(bus_out), .start_pulse(start_pulse), .key_field(key_field),
        .block_field(block_field), .iter_count(iter_count)
    );

    task automatic chk(input string req, input string what, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] wgen(input int i, input logic [31:0] seed);
        return seed ^ (32'h01020304 * (i + 1)) ^ {i[7:0], 24'h5A3C00};
    endfunction

    task automatic t_reset();
        chk("R1", "start", {159'b0, start_pulse}, 160'd0);
        chk("R1", "bus_out", {128'b0, bus_out}, 160'd0);
        chk("R1", "count", {128'b0, iter_count}, 160'd0);
        chk("R1", "block", block_field, 160'd0);
        chk("R1", "key_or", {159'b0, |key_field}, 160'd0);
    endtask

    task automatic t_fill(input logic [31:0] seed);
        for (int i = 0; i < 22; i++) begin
            in_en = 1'b1;
            bus_in = wgen(i, seed);
            tick();
            chk("R2", "newest word in count", {128'b0, iter_count}, {128'b0, wgen(i, seed)});
            chk("R6", "no start while level high", {159'b0, start_pulse}, 160'd0);
        end
        in_en = 1'b0;
        bus_in = 32'hDEAD_BEEF;
        tick();
        chk("R5", "start after fall", {159'b0, start_pulse}, 160'd1);
        for (int i = 0; i < 16; i++)
            chk("R3", "key word", {128'b0, key_field[511-32*i -: 32]}, {128'b0, wgen(i, seed)});
        for (int i = 16; i < 21; i++)
            chk("R3", "block word", {128'b0, block_field[159-32*(i-16) -: 32]}, {128'b0, wgen(i, seed)});
        chk("R3", "count word", {128'b0, iter_count}, {128'b0, wgen(21, seed)});
        tick();
        chk("R5", "start one cycle only", {159'b0, start_pulse}, 160'd0);
    endtask

    task automatic t_hold();
        logic [511:0] k;
        logic [159:0] b;
        logic [31:0] c;
        k = key_field; b = block_field; c = iter_count;
        for (int i = 0; i < 4; i++) begin
            bus_in = 32'h1111_0000 + i;
            tick();
            chk("R4", "block held", block_field, b);
            chk("R4", "count held", {128'b0, iter_count}, {128'b0, c});
            chk("R4", "key held", {159'b0, key_field == k}, 160'd1);
            chk("R6", "no start while low", {159'b0, start_pulse}, 160'd0);
        end
    endtask

    task automatic t_short_pulse();
        in_en = 1'b1;
        bus_in = 32'h0BAD_CAFE;
        tick();
        chk("R6", "no start on rise", {159'b0, start_pulse}, 160'd0);
        in_en = 1'b0;
        tick();
        chk("R5", "start after one-cycle high", {159'b0, start_pulse}, 160'd1);
        tick();
        chk("R5", "pulse ends", {159'b0, start_pulse}, 160'd0);
    endtask

    task automatic t_unload(input logic [159:0] r);
        res_load = 1'b1;
        res_word = r;
        tick();
        res_load = 1'b0;
        res_word = '0;
        chk("R7", "top word after load", {128'b0, bus_out}, {128'b0, r[159:128]});
        tick();
        chk("R10", "idle hold", {128'b0, bus_out}, {128'b0, r[159:128]});
        out_en = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            tick();
            if (k < 5)
                chk("R8", "shifted word", {128'b0, bus_out}, {128'b0, r[159-32*k -: 32]});
            else
                chk("R8", "empty after five", {128'b0, bus_out}, 160'd0);
        end
        out_en = 1'b0;
    endtask

    task automatic t_priority(input logic [159:0] r1, input logic [159:0] r2);
        res_load = 1'b1; res_word = r1;
        tick();
        res_load = 1'b0; out_en = 1'b1;
        tick();
        chk("R8", "first shift", {128'b0, bus_out}, {128'b0, r1[127:96]});
        res_load = 1'b1; res_word = r2;
        tick();
        chk("R9", "load beats shift", {128'b0, bus_out}, {128'b0, r2[159:128]});
        res_load = 1'b0;
        tick();
        chk("R9", "shift resumes on new value", {128'b0, bus_out}, {128'b0, r2[127:96]});
        out_en = 1'b0;
        tick();
        tick();
        chk("R10", "hold with enables low", {128'b0, bus_out}, {128'b0, r2[127:96]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_fill(32'hC001_D00D);
        t_hold();
        t_short_pulse();
        t_fill(32'h7E57_0042);
        t_unload(160'h0123456789ABCDEF_FEDCBA9876543210_A5A5C3C3);
        t_priority(160'h11111111_22222222_33333333_44444444_55555555,
                   160'h99999999_AAAAAAAA_BBBBBBBB_CCCCCCCC_DDDDDDDD);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule